// File: doc/BRIEF.md
# UART Interrupt Event Latch

This block sits between the FIFO logic of a serial port and the processor. It watches three internal conditions: the receive FIFO reaching its trigger level, a receive timeout, and the transmit FIFO dropping below its threshold. A rising edge on any of them sets a sticky pending flag.

Software reads the flags in a status register and clears each one by writing 1 to its bit. A control register holds one enable per source. The block drives one level-sensitive interrupt line, which stays high while any enabled flag is pending.

Because the sources are edge-detected, a condition that is already true when its enable is set raises nothing. The driver must start transmission by filling the FIFO itself. The interrupt then arrives on the next transition of the condition.

Top module: `uart_event_irq`

## Requirements
- R1: After reset the control register, the status register, the read data and `irq` are all 0.
- R2: A pending flag is set only on a low-to-high transition of its condition. A condition that stays high does not set the flag again after it has been cleared.
- R3: The receive-threshold condition is true when `rx_count` >= `RX_TRIG`. The defaults are a trigger of 8 and a depth of 16.
- R4: Control register (index 0) enable bit positions: bit 12 is receive threshold, bit 9 is receive timeout, bit 13 is transmit threshold. All other bits read 0.
- R5: Status register (index 1) pending bit positions: bit 4 is receive threshold, bit 5 is transmit threshold, bit 9 is receive timeout. All other bits read 0. Indices 2 and 3 read 0.
- R6: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. Writing 0x3F0 clears all three flags.
- R7: When a rising edge and a write-1 clear of the same flag fall in the same cycle, the flag stays pending.
- R8: `irq` is the OR over the sources of (pending AND enable). It is registered, and it rises at the same clock edge that sets the flag.
- R9: Clearing an enable drops `irq` but leaves the pending flag set.
- R10: Setting the transmit-threshold enable while `tx_below` is already high does not raise `irq`.
- R11: A condition that is high during reset and stays high afterwards does not set its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 is control, 1 is status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| rx_count | input | $clog2(RX_DEPTH+1) | Current receive FIFO fill level |
| rx_timeout | input | 1 | Receive timeout condition |
| tx_below | input | 1 | Transmit FIFO below its threshold |
| irq | output | 1 | Level interrupt request |

## Verification
A condition edge that the bench drives after a falling clock edge is captured at the next rising edge. Both the pending flag and `irq` change at that rising edge, so the bench samples `irq` one falling edge later.

A register write takes effect at the single rising edge it spans. Read data is registered from the address presented before a rising edge, so every read sets the address at one falling edge and samples at the next. The same-cycle set/clear case drives the edge and the clear on the same falling edge.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_RXTH = 0;
  localparam int SRC_RXTO = 1;
  localparam int SRC_TXTH = 2;

  // Enable bit position in the control register, per source.
  localparam int EN_POS   [NSRC] = '{12, 9, 13};
  // Pending bit position in the status register, per source.
  localparam int STAT_POS [NSRC] = '{4, 9, 5};

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
endpackage

// File: rtl/rx_level_cmp.sv
module rx_level_cmp #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic             reached
);
  localparam logic [CNT_W-1:0] TRIG_V = CNT_W'(TRIG);
  assign reached = (count >= TRIG_V);
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic clr,
  output logic pend,
  output logic pend_d
);
  logic cond_q;
  logic rise;

  assign rise = cond & ~cond_q;

  always_comb begin
    if (rise)      pend_d = 1'b1;
    else if (clr)  pend_d = 1'b0;
    else           pend_d = pend;
  end

  always_ff @(posedge clk) begin
    cond_q <= cond;
    if (rst) pend <= 1'b0;
    else     pend <= pend_d;
  end

  // R2 / R7: a rising edge always leaves the flag pending
  p_set_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (cond && !cond_q) |=> pend);
  // R2: no edge and not pending means it stays clear
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    (!pend && !(cond && !cond_q)) |=> !pend);
  // R6: clear without a competing edge drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !(cond && !cond_q)) |=> !pend);
  // R6: flag holds when not cleared
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/uart_event_irq.sv
module uart_event_irq #(
  parameter int RX_DEPTH = 16,
  parameter int RX_TRIG  = 8,
  parameter int DATA_W   = 32,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_timeout,
  input  logic              tx_below,
  output logic              irq
);
  import serial_irq_pkg::*;

  logic [NSRC-1:0] cond_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic            rx_reached;
  logic            wr_ctrl;
  logic            wr_stat;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] stat_view;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata;

  rx_level_cmp #(.DEPTH(RX_DEPTH), .TRIG(RX_TRIG)) u_rx_cmp (
    .count   (rx_count),
    .reached (rx_reached)
  );

  always_comb begin
    cond_vec           = '0;
    cond_vec[SRC_RXTH] = rx_reached;
    cond_vec[SRC_RXTO] = rx_timeout;
    cond_vec[SRC_TXTH] = tx_below;
  end

  assign wr_ctrl = reg_we && (reg_addr == IDX_CTRL);
  assign wr_stat = reg_we && (reg_addr == IDX_STAT);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign clr_vec[g] = wr_stat && reg_wdata[STAT_POS[g]];
    assign en_d[g]    = wr_ctrl ? reg_wdata[EN_POS[g]] : en_q[g];

    irq_edge_latch u_latch (
      .clk    (clk),
      .rst    (rst),
      .cond   (cond_vec[g]),
      .clr    (clr_vec[g]),
      .pend   (pend_q[g]),
      .pend_d (pend_d[g])
    );
  end

  always_comb begin
    ctrl_view = '0;
    stat_view = '0;
    for (int i = 0; i < NSRC; i++) begin
      ctrl_view[EN_POS[i]]   = en_q[i];
      stat_view[STAT_POS[i]] = pend_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      en_q <= en_d;
      irq  <= |(pend_d & en_d);
      case (reg_addr)
        IDX_CTRL: reg_rdata <= ctrl_view;
        IDX_STAT: reg_rdata <= stat_view;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R8: the registered line tracks the enabled flags
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend_q & en_q));
  // R9: dropping enables never clears flags
  p_en_off_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wr_stat && (pend_q != '0)) |=> (pend_q != '0));
  // R4: a control write lands in the enables
  p_ctrl_write_r4: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> en_q[SRC_TXTH] == $past(reg_wdata[EN_POS[SRC_TXTH]]));
  // R1: idle after reset
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && pend_q == '0 && !irq));
endmodule

// File: tb/test_uart_event_irq.sv
`timescale 1ns/1ps
module test_uart_event_irq;
  localparam int DW = 32;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [CW-1:0] rx_count = '0;
  logic          rx_timeout = 1'b1;
  logic          tx_below = 1'b1;
  logic          irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  uart_event_irq i_uart_event_irq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_count(rx_count),
    .rx_timeout(rx_timeout), .tx_below(tx_below), .irq(irq)
  );

  function automatic logic [31:0] en_bit(input int s);
    case (s)
      0: return 32'h1 << 12;
      1: return 32'h1 << 9;
      default: return 32'h1 << 13;
    endcase
  endfunction

  function automatic logic [31:0] st_bit(input int s);
    case (s)
      0: return 32'h1 << 4;
      1: return 32'h1 << 9;
      default: return 32'h1 << 5;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic set_cond(input int s, input logic v);
    case (s)
      0: rx_count = v ? CW'(8) : CW'(0);
      1: rx_timeout = v;
      default: tx_below = v;
    endcase
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 / R11: conditions held high through reset set nothing
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(2'd1, v); check("R11 status with high conditions", v, 32'h0);
    rd(2'd0, v); check("R1 control after reset", v, 32'h0);

    // R10: enabling TX while already below threshold
    wr(2'd0, en_bit(2));
    repeat (2) @(negedge clk);
    check("R10 no irq on enable", {31'b0, irq}, 32'h0);
    tx_below = 1'b0; @(negedge clk);
    tx_below = 1'b1; @(negedge clk);
    check("R8 irq on new TX edge", {31'b0, irq}, 32'h1);

    // R9: dropping the enable drops irq, flag kept
    wr(2'd0, 32'h0);
    check("R9 irq off after disable", {31'b0, irq}, 32'h0);
    rd(2'd1, v); check("R9 flag kept", v, st_bit(2));

    // R2: held-high timeout gives one edge, none after clear
    rx_timeout = 1'b0; @(negedge clk);
    rx_timeout = 1'b1; @(negedge clk);
    rd(2'd1, v); check("R2 two flags pending", v, st_bit(2) | st_bit(1));
    // R6: write 0 changes nothing
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R6 write zero no effect", v, st_bit(2) | st_bit(1));
    wr(2'd1, st_bit(1));
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R2 level does not re-set", v, st_bit(2));

    // R4 / R5: bit positions and masked bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R4 control readback", v, 32'h0000_3200);
    rx_count = CW'(8); @(negedge clk);
    rx_timeout = 1'b0; @(negedge clk);
    rx_timeout = 1'b1; @(negedge clk);
    rd(2'd1, v); check("R5 all flags", v, 32'h0000_0230);
    rd(2'd2, v); check("R5 unused index", v, 32'h0);
    wr(2'd1, 32'h3F0);
    rd(2'd1, v); check("R6 clear all", v, 32'h0);
    check("R8 irq low after clear", {31'b0, irq}, 32'h0);

    // R7: edge and clear in the same cycle
    rx_timeout = 1'b0; @(negedge clk);
    rx_timeout = 1'b1; @(negedge clk);
    rx_timeout = 1'b0; @(negedge clk);
    rx_timeout = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = st_bit(1);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(2'd1, v); check("R7 set wins over clear", v, st_bit(1));
    check("R7 irq still high", {31'b0, irq}, 32'h1);

    // Sweep: every source against every enable mask (R8)
    rx_count = '0; rx_timeout = 1'b0; tx_below = 1'b0;
    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] en;
        en = 32'h0;
        for (int k = 0; k < 3; k++) if (m[k]) en |= en_bit(k);
        wr(2'd0, en);
        wr(2'd1, 32'h3F0);
        check("R8 idle before pulse", {31'b0, irq}, 32'h0);
        set_cond(s, 1'b1); @(negedge clk);
        check("R8 irq per mask", {31'b0, irq}, {31'b0, m[s]});
        set_cond(s, 1'b0);
        rd(2'd1, v); check("R5 flag per source", v, st_bit(s));
      end
    end

    // Sweep: receive fill level against trigger (R3)
    wr(2'd0, en_bit(0));
    for (int c = 0; c <= 16; c++) begin
      rx_count = '0;
      wr(2'd1, 32'h3F0);
      rx_count = CW'(c); @(negedge clk);
      check("R3 irq vs level", {31'b0, irq}, {31'b0, (c >= 8)});
      rd(2'd1, v); check("R3 flag vs level", v, (c >= 8) ? st_bit(0) : 32'h0);
    end

    // R1: reset mid-run clears everything
    @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(2'd0, v); check("R1 control after second reset", v, 32'h0);
    check("R1 irq after second reset", {31'b0, irq}, 32'h0);

    finish_run();
  end
endmodule